// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block sits between a word-addressed processor and a main memory of 64K words reached through 16-bit addresses. It keeps 64 sets of two lines, and each line holds 16 words. A processor read or write that finds its line in the set finishes from the cache. When the line is absent, the controller chooses a victim way. If that victim holds modified data, the controller copies the victim line out to memory. It then loads the addressed line and completes the access from the cache.

The processor keeps `cpuReq` and its operands steady until `cpuReady` pulses. The memory side moves one line at a time, one word per cycle. Each word moves in a cycle in which the controller holds `memReq` and memory answers with `memAck`. A writer can therefore stall the burst at any word. Every write marks its line modified, and a write miss allocates the line before it writes. The victim is the least recently used way of the set, and an empty way is always taken before an occupied one.

Top module: `cache_top`

## Requirements
- R1: An address splits, from high bits to low, into a 6-bit tag [15:10], a 6-bit set index [9:4] and a 4-bit word offset [3:0]. The line number put on `memLine` is {tag, set}. Address 0x357A therefore touches line 855, with tag 13 in set 23.
- R2: A read that hits pulses `cpuReady` in the cycle after the clock edge that accepted the request. `cpuRdata` then carries the addressed word.
- R3: A read miss loads the addressed line before it completes. `cpuReady` rises in the cycle after the last refill word. The returned word is the most recent value written to that address, or the memory content if the address was never written.
- R4: A write stores its word in the cached line and marks the line modified, whether it hits or misses. A write hit completes one cycle after acceptance. A write miss first loads the line from memory (16 refill words).
- R5: When both ways of a set are valid, a miss replaces the way that was accessed less recently. The other way stays resident and still hits.
- R6: Reset invalidates every line. A miss in a set with an invalid way fills that way without evicting the other one.
- R7: A victim marked modified is written to memory as 16 words under the victim's own line number before the refill. A victim that is not modified causes no memory writes.
- R8: Each burst moves words 0 to 15 in ascending order on `memWord`. The burst advances only in cycles with `memAck`, and a write-back finishes before its refill begins (`memWe` high during the write-back, low during the refill).
- R9: `cpuReady` lasts exactly one cycle per access, and `memReq` is low whenever `cpuReady` is high.
- R10: During and right after reset, `cpuReady` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Word address |
| cpuWdata | input | 16 | Write data |
| cpuRdata | output | 16 | Read data, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory burst in progress |
| memWe | output | 1 | 1 = write-back burst, 0 = refill burst |
| memLine | output | 12 | Line number {tag, set} of the burst |
| memWord | output | 4 | Word index within the burst |
| memWdata | output | 16 | Write-back word |
| memRdata | input | 16 | Refill word for memLine/memWord |
| memAck | input | 1 | Memory takes or delivers the current word this cycle |

## Verification
The hardest case to reach is a modified victim that is also the least recently used way. It only arises after both ways of a set have been filled, one of them has been written, and the other one has been touched more recently. The stimulus builds this state in set 23 through a fixed sequence of reads and writes with chosen tags. It then checks the write-back word count, the victim line number and that the write-back ends before the refill starts. A sweep of four tags over all 64 sets repeats this eviction in every set while memory stalls every third cycle. Reading every written word back afterwards shows that no data was lost.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } ctrlState_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic latchReq;
    logic latchVictim;
    logic cntClr;
    logic cntInc;
    logic fillWord;
    logic fillDone;
    logic accessDo;
  } dpCtrl_t;

endpackage

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    memAck,
  input  logic    hit,
  input  logic    victimDirty,
  input  logic    cntLast,
  output logic    cpuReady,
  output logic    memReq,
  output logic    memWe,
  output dpCtrl_t ctl
);

  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    ctl      = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          ctl.latchReq = 1'b1;
          stateD       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          ctl.accessDo = 1'b1;
          cpuReady     = 1'b1;
          stateD       = ST_IDLE;
        end else begin
          ctl.latchVictim = 1'b1;
          ctl.cntClr      = 1'b1;
          stateD          = victimDirty ? ST_WRITEBACK : ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          ctl.cntInc = 1'b1;
          if (cntLast) stateD = ST_REFILL;
        end
      end
      ST_REFILL: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.fillWord = 1'b1;
          ctl.cntInc   = 1'b1;
          if (cntLast) begin
            ctl.fillDone = 1'b1;
            stateD       = ST_RESPOND;
          end
        end
      end
      ST_RESPOND: begin
        ctl.accessDo = 1'b1;
        cpuReady     = 1'b1;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16,
  localparam int LINE_W = TAG_W + SET_W,
  localparam int ADDR_W = LINE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              memWe,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic              cntLast,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [LINE_W-1:0] memLine,
  output logic [OFF_W-1:0]  memWord,
  output logic [DATA_W-1:0] memWdata
);

  localparam int SETS   = 1 << SET_W;
  localparam int NWORDS = SETS * 2 * (1 << OFF_W);
  localparam int IDX_W  = SET_W + 1 + OFF_W;

  logic [TAG_W-1:0]  tagMem   [SETS][2];
  logic [1:0]        validMem [SETS];
  logic [1:0]        dirtyMem [SETS];
  logic [SETS-1:0]   lruBits;              // way to evict next
  logic [DATA_W-1:0] dataMem  [NWORDS];

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWe;
  logic [DATA_W-1:0] reqWdata;
  logic              victimQ;
  logic [OFF_W-1:0]  cnt;

  logic [TAG_W-1:0] reqTag;
  logic [SET_W-1:0] reqSet;
  logic [OFF_W-1:0] reqWord;
  logic [1:0]       hitVec;
  logic             hitWay;
  logic             victimComb;

  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet  = reqAddr[OFF_W +: SET_W];
  assign reqWord = reqAddr[OFF_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hitVec[w] = validMem[reqSet][w] && (tagMem[reqSet][w] == reqTag);
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  always_comb begin
    if (!validMem[reqSet][0])      victimComb = 1'b0;
    else if (!validMem[reqSet][1]) victimComb = 1'b1;
    else                           victimComb = lruBits[reqSet];
  end

  assign victimDirty = validMem[reqSet][victimComb] && dirtyMem[reqSet][victimComb];
  assign cntLast     = (cnt == {OFF_W{1'b1}});

  logic [IDX_W-1:0] hitIdx, burstIdx;
  assign hitIdx   = {reqSet, hitWay, reqWord};
  assign burstIdx = {reqSet, victimQ, cnt};

  assign cpuRdata = dataMem[hitIdx];
  assign memWdata = dataMem[burstIdx];
  assign memWord  = cnt;
  assign memLine  = memWe ? {tagMem[reqSet][victimQ], reqSet} : {reqTag, reqSet};

  always_ff @(posedge clk) begin
    if (ctl.fillWord)                dataMem[burstIdx] <= memRdata;
    else if (ctl.accessDo && reqWe)  dataMem[hitIdx]   <= reqWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWe    <= 1'b0;
      reqWdata <= '0;
      victimQ  <= 1'b0;
      cnt      <= '0;
      lruBits  <= '0;
      for (int s = 0; s < SETS; s++) begin
        validMem[s]  <= 2'b00;
        dirtyMem[s]  <= 2'b00;
        tagMem[s][0] <= '0;
        tagMem[s][1] <= '0;
      end
    end else begin
      if (ctl.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWe    <= cpuWe;
        reqWdata <= cpuWdata;
      end
      if (ctl.latchVictim) victimQ <= victimComb;
      if (ctl.cntClr)      cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
      if (ctl.fillDone) begin
        tagMem[reqSet][victimQ]   <= reqTag;
        validMem[reqSet][victimQ] <= 1'b1;
        dirtyMem[reqSet][victimQ] <= 1'b0;
      end
      if (ctl.accessDo) begin
        lruBits[reqSet] <= ~hitWay;
        if (reqWe) dirtyMem[reqSet][hitWay] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cache_top.sv
module cache_top
  import cache_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16,
  localparam int LINE_W = TAG_W + SET_W,
  localparam int ADDR_W = LINE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [LINE_W-1:0] memLine,
  output logic [OFF_W-1:0]  memWord,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  dpCtrl_t ctl;
  logic    hit, victimDirty, cntLast;

  cache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReq      (cpuReq),
    .memAck      (memAck),
    .hit         (hit),
    .victimDirty (victimDirty),
    .cntLast     (cntLast),
    .cpuReady    (cpuReady),
    .memReq      (memReq),
    .memWe       (memWe),
    .ctl         (ctl)
  );

  cache_dp #(
    .TAG_W (TAG_W),
    .SET_W (SET_W),
    .OFF_W (OFF_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .memWe       (memWe),
    .cpuWe       (cpuWe),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .memRdata    (memRdata),
    .hit         (hit),
    .victimDirty (victimDirty),
    .cntLast     (cntLast),
    .cpuRdata    (cpuRdata),
    .memLine     (memLine),
    .memWord     (memWord),
    .memWdata    (memWdata)
  );

endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int SET_W  = 6,
  parameter int OFF_W  = 4,
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [LINE_W-1:0] memLine,
  input logic [OFF_W-1:0]  memWord
);

  localparam logic [OFF_W-1:0] LAST_W = {OFF_W{1'b1}};
  localparam logic [OFF_W-1:0] ONE_W  = {{(OFF_W-1){1'b0}}, 1'b1};

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);  // R9

  AST_READY_MEM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !memReq);  // R9

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memWord != LAST_W) |=>
      (memReq && memWord == $past(memWord) + ONE_W));  // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=>
      (memReq && $stable(memWord) && $stable(memWe) && $stable(memLine)));  // R8

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memWe && memWord == LAST_W) |=>
      (memReq && !memWe && memWord == '0 &&
       memLine[SET_W-1:0] == $past(memLine[SET_W-1:0])));  // R7

  AST_FILL_THEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !memWe && memWord == LAST_W) |=> cpuReady);  // R3

endmodule

bind cache_top cache_chk #(
  .SET_W (SET_W),
  .OFF_W (OFF_W),
  .LINE_W(LINE_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReady(cpuReady),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAck  (memAck),
  .memLine (memLine),
  .memWord (memWord)
);

// File: tb/cache_top_tb.sv
module cache_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuReq, cpuWe;
  logic [15:0] cpuAddr, cpuWdata, cpuRdata;
  logic        cpuReady;
  logic        memReq, memWe;
  logic [11:0] memLine;
  logic [3:0]  memWord;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_top u_dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memLine(memLine), .memWord(memWord),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0;
  int fails  = 0;

  // backing memory and reference contents
  logic [15:0] memStore [int];
  logic [15:0] refMem   [int];

  function automatic logic [15:0] initVal(input logic [15:0] a);
    return (a * 16'd7) ^ 16'h1234;
  endfunction

  function automatic logic [15:0] readMem(input int a);
    if (memStore.exists(a)) return memStore[a];
    return initVal(a[15:0]);
  endfunction

  function automatic logic [15:0] expVal(input logic [15:0] a);
    if (refMem.exists(int'(a))) return refMem[int'(a)];
    return initVal(a);
  endfunction

  function automatic logic [15:0] mkAddr(input int t, input int s, input int w);
    return {t[5:0], s[5:0], w[3:0]};
  endfunction

  // memory model: stall every third cycle
  int ackCnt = 0;
  always @(negedge clk) begin
    ackCnt++;
    memAck   = (ackCnt % 3) != 0;
    memRdata = readMem({memLine, memWord});
  end

  // traffic monitor
  int          wbWords, fillWords, wbAtFill;
  logic [11:0] wbLine, fillLine;
  bit          orderBad = 0;
  always @(posedge clk) begin
    if (memReq && memAck) begin
      if (memWe) begin
        if (int'(memWord) != wbWords % 16) orderBad = 1;
        if (fillWords % 16 != 0) orderBad = 1;
        memStore[{memLine, memWord}] = memWdata;
        wbLine = memLine;
        wbWords++;
      end else begin
        if (int'(memWord) != fillWords % 16) orderBad = 1;
        if (fillWords == 0) wbAtFill = wbWords;
        fillLine = memLine;
        fillWords++;
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int cyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    wbWords = 0; fillWords = 0; wbAtFill = -1;
    cyc = 0;
    rd  = '0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cpuReady) begin
        rd = cpuRdata;
        break;
      end
      if (cyc > 3000) begin
        cyc = -1;
        break;
      end
    end
    cpuReq = 1'b0;
    if (we && cyc > 0) refMem[int'(a)] = d;
  endtask

  logic [15:0] rd;
  int          cyc;

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    repeat (4) @(negedge clk);
    chk("R10", "ready in reset", cpuReady, 0);
    chk("R10", "memReq in reset", memReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "ready after reset", cpuReady, 0);
    chk("R10", "memReq after reset", memReq, 0);

    // write miss to 0x357A: allocate, decode
    access(1'b1, 16'h357A, 16'hBEEF, rd, cyc);
    chk("R1", "refill line of 0x357A", fillLine, 855);
    chk("R1", "set field", fillLine[5:0], 23);
    chk("R1", "tag field", fillLine[11:6], 13);
    chk("R4", "write miss refill words", fillWords, 16);
    chk("R6", "no write-back into empty way", wbWords, 0);
    chk("R4", "write miss slower than hit", cyc > 16, 1);

    access(1'b0, 16'h357A, 16'h0, rd, cyc);
    chk("R2", "read hit latency", cyc, 1);
    chk("R2", "read hit data", rd, 16'hBEEF);
    access(1'b0, 16'h3570, 16'h0, rd, cyc);
    chk("R2", "hit other word latency", cyc, 1);
    chk("R3", "word loaded by refill", rd, initVal(16'h3570));

    // second tag in set 23 fills the empty way
    access(1'b0, mkAddr(2, 23, 3), 16'h0, rd, cyc);
    chk("R3", "read miss data", rd, initVal(mkAddr(2, 23, 3)));
    chk("R3", "read miss refill words", fillWords, 16);
    chk("R6", "empty way used, no eviction", wbWords, 0);
    access(1'b0, 16'h357A, 16'h0, rd, cyc);
    chk("R6", "first line still resident", cyc, 1);

    // LRU: tag 2 is older, gets replaced by tag 5 (clean)
    access(1'b0, mkAddr(5, 23, 0), 16'h0, rd, cyc);
    chk("R5", "clean LRU victim not written", wbWords, 0);
    chk("R3", "data of tag 5", rd, initVal(mkAddr(5, 23, 0)));
    access(1'b0, 16'h357A, 16'h0, rd, cyc);
    chk("R5", "more recent way survived", cyc, 1);
    access(1'b0, mkAddr(2, 23, 3), 16'h0, rd, cyc);
    chk("R5", "evicted line misses again", fillWords, 16);
    chk("R7", "clean victim no write-back", wbWords, 0);

    // dirty LRU victim (tag 13) written back before refill
    access(1'b0, mkAddr(7, 23, 1), 16'h0, rd, cyc);
    chk("R7", "dirty victim write-back words", wbWords, 16);
    chk("R7", "write-back line number", wbLine, 855);
    chk("R8", "write-back done before refill", wbAtFill, 16);
    chk("R1", "refill line of tag 7", fillLine, (7 << 6) | 23);
    access(1'b0, 16'h357A, 16'h0, rd, cyc);
    chk("R7", "written-back data returns", rd, 16'hBEEF);
    chk("R3", "re-fetch after eviction", fillWords, 16);

    // write hit marks a clean line modified
    access(1'b1, 16'h3571, 16'h1111, rd, cyc);
    chk("R4", "write hit latency", cyc, 1);
    chk("R4", "write hit no memory traffic", fillWords + wbWords, 0);
    access(1'b0, mkAddr(7, 23, 1), 16'h0, rd, cyc);
    chk("R5", "tag 7 hit", cyc, 1);
    access(1'b0, mkAddr(9, 23, 0), 16'h0, rd, cyc);
    chk("R4", "line dirtied by write hit is written back", wbWords, 16);
    chk("R4", "write-back line", wbLine, 855);
    access(1'b0, 16'h3571, 16'h0, rd, cyc);
    chk("R4", "write hit data survives eviction", rd, 16'h1111);

    // reset invalidates all lines
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    access(1'b0, 16'h3571, 16'h0, rd, cyc);
    chk("R6", "reset invalidates line", fillWords, 16);
    chk("R6", "data after reset", rd, 16'h1111);

    // sweep: four tags over every set, repeated dirty evictions
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 64; s++) begin
        access(1'b1, mkAddr(t, s, (t + s) % 16), 16'((t * 64 + s) * 37 + 5), rd, cyc);
        if (cyc < 0) chk("R4", "sweep write timeout", cyc, 1);
      end
    end
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 64; s++) begin
        access(1'b0, mkAddr(t, s, (t + s) % 16), 16'h0, rd, cyc);
        chk("R3", "sweep readback", rd, expVal(mkAddr(t, s, (t + s) % 16)));
      end
    end
    access(1'b0, mkAddr(3, 40, 0), 16'h0, rd, cyc);
    chk("R3", "unwritten word of swept line", rd, initVal(mkAddr(3, 40, 0)));

    chk("R8", "ascending word order, no interleave", orderBad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule